// File: doc/BRIEF.md
# Serial Passthrough Address and Write-Payload Rewriter

This block sits on the single-bit host-to-flash data line of a serial flash passthrough path. A phase tracker elsewhere tells it when a new command begins, which phase the current bit belongs to (address or payload) and whether a shift slot carries a valid bit. The block then either forwards each incoming bit unchanged or replaces it on the fly, in the same slot, without adding latency.

Two rewrites are available, and each is chosen per command. The address rewrite replaces every address bit with the matching bit of a preset address value. The address is 24 or 32 bits long, depending on the command's address mode. The payload rewrite affects only the first 32 payload bits of a single-lane write. For each of those bits, the output is the preset data bit where the mask bit is 1, and the incoming bit where the mask bit is 0. The per-command settings are captured when a command starts. The preset address, mask and data values are used live.

Top module: `spi_pt_swap`

## Requirements
- R1: With address mode 2'b10 (fixed short) and address rewrite enabled, the i-th valid address bit (i = 0..23, most significant first) leaves as `swap_addr[23-i]`.
- R2: With address mode 2'b11 (fixed long) and address rewrite enabled, the i-th valid address bit (i = 0..31) leaves as `swap_addr[31-i]`.
- R3: With address mode 2'b01, the address length is 32 bits when `cmd_addr_4b_cfg` is 1 at command start, and 24 bits when it is 0.
- R4: With address mode 2'b00, or with `cmd_addr_swap_en` 0 at command start, address bits pass through unchanged.
- R5: Address bits that arrive after the resolved address length pass through unchanged.
- R6: With payload rewrite active, the j-th valid payload bit (j = 0..31) leaves as `pay_data[31-j]` when `pay_mask[31-j]` is 1, and as the incoming bit otherwise.
- R7: Payload bits after the 32nd pass through unchanged.
- R8: Payload rewrite is active only if, at command start, `cmd_pay_swap_en` is 1, `cmd_pay_lanes` is 4'b0001 and `cmd_pay_dir` is 0 (host to device). In any other case payload bits pass through.
- R9: `out_bit` responds to `in_bit` combinationally in the same slot. It equals `in_bit` whenever `bit_valid` is 0 or neither phase input is high.
- R10: A `cmd_start` pulse captures the command settings and restarts the bit positions of both phases. Changes to the command setting inputs after that pulse have no effect until the next pulse.
- R11: After reset, no rewrite is active, so address and payload bits pass through until the first `cmd_start`.
- R12: A slot with `bit_valid` low does not advance the address or payload bit position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift-slot clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Pulse: a new command begins; settings are captured |
| cmd_addr_mode | input | 2 | 00 none, 01 length by cfg, 10 24 bits, 11 32 bits |
| cmd_addr_4b_cfg | input | 1 | Long-address selector used by mode 01 |
| cmd_addr_swap_en | input | 1 | Rewrite the address of this command |
| cmd_pay_swap_en | input | 1 | Rewrite the first 32 payload bits |
| cmd_pay_lanes | input | 4 | Payload lane enables of this command |
| cmd_pay_dir | input | 1 | Payload direction, 0 host to device |
| addr_phase | input | 1 | Current slot is in the address phase |
| payload_phase | input | 1 | Current slot is in the payload phase |
| bit_valid | input | 1 | Current slot carries a data bit |
| in_bit | input | 1 | Bit from the host |
| swap_addr | input | 32 | Replacement address value |
| pay_mask | input | 32 | Per-bit payload rewrite mask |
| pay_data | input | 32 | Payload replacement bits |
| out_bit | output | 1 | Bit toward the flash device |

## Verification
A wrong bit position shows at the ports as a skew: the replacement pattern is shifted by one or more places. Because the preset values are asymmetric, this shows on the first few address or payload bits after a command start. A stale or wrong captured setting shows on the very first valid bit of the phase, which either leaves rewritten when it should pass, or passes when it should be rewritten. A counter that fails to saturate or to hold through an invalid slot shows in the bits just past the 24th or 32nd position, or in the bit right after a gap.

// File: rtl/spi_pt_swap.sv
module spi_pt_swap #(
  parameter int AddrMaxBits = 32,
  parameter int SwapBits    = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_start,
  input  logic [1:0]             cmd_addr_mode,
  input  logic                   cmd_addr_4b_cfg,
  input  logic                   cmd_addr_swap_en,
  input  logic                   cmd_pay_swap_en,
  input  logic [3:0]             cmd_pay_lanes,
  input  logic                   cmd_pay_dir,
  input  logic                   addr_phase,
  input  logic                   payload_phase,
  input  logic                   bit_valid,
  input  logic                   in_bit,
  input  logic [AddrMaxBits-1:0] swap_addr,
  input  logic [SwapBits-1:0]    pay_mask,
  input  logic [SwapBits-1:0]    pay_data,
  output logic                   out_bit
);
  localparam int CntW       = $clog2(AddrMaxBits + 1);
  localparam int PCntW      = $clog2(SwapBits + 1);
  localparam int ShortBits  = AddrMaxBits - 8;

  logic             addr_on, addr_long, pay_on;
  logic [CntW-1:0]  addr_cnt;
  logic [PCntW-1:0] pay_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_on   <= 1'b0;
      addr_long <= 1'b0;
      pay_on    <= 1'b0;
      addr_cnt  <= '0;
      pay_cnt   <= '0;
    end else if (cmd_start) begin
      addr_on   <= cmd_addr_swap_en && (cmd_addr_mode != 2'b00);
      addr_long <= (cmd_addr_mode == 2'b11) || ((cmd_addr_mode == 2'b01) && cmd_addr_4b_cfg);
      pay_on    <= cmd_pay_swap_en && (cmd_pay_lanes == 4'b0001) && !cmd_pay_dir;
      addr_cnt  <= '0;
      pay_cnt   <= '0;
    end else if (bit_valid) begin
      if (addr_phase && addr_cnt != CntW'(AddrMaxBits))
        addr_cnt <= addr_cnt + CntW'(1);
      if (payload_phase && !addr_phase && pay_cnt != PCntW'(SwapBits))
        pay_cnt <= pay_cnt + PCntW'(1);
    end
  end

  logic [CntW-1:0]        addr_len, addr_idx;
  logic [PCntW-1:0]       pay_idx;
  logic [AddrMaxBits-1:0] sel_a;
  logic [SwapBits-1:0]    sel_p;
  logic                   addr_hit, pay_hit, a_bit, p_bit;

  assign addr_len = addr_long ? CntW'(AddrMaxBits) : CntW'(ShortBits);
  assign addr_idx = addr_len - addr_cnt - CntW'(1);
  assign pay_idx  = PCntW'(SwapBits) - pay_cnt - PCntW'(1);
  assign sel_a    = {{(AddrMaxBits-1){1'b0}}, 1'b1} << addr_idx;
  assign sel_p    = {{(SwapBits-1){1'b0}}, 1'b1} << pay_idx;

  assign addr_hit = bit_valid && addr_phase && addr_on && (addr_cnt < addr_len);
  assign pay_hit  = bit_valid && payload_phase && !addr_phase && pay_on &&
                    (pay_cnt < PCntW'(SwapBits));
  assign a_bit    = |(swap_addr & sel_a);
  assign p_bit    = (|(pay_mask & sel_p)) ? (|(pay_data & sel_p)) : in_bit;

  assign out_bit  = addr_hit ? a_bit : (pay_hit ? p_bit : in_bit);
endmodule

// File: rtl/spi_pt_swap_chk.sv
module spi_pt_swap_chk #(
  parameter int AddrMaxBits = 32,
  parameter int SwapBits    = 32,
  parameter int CntW        = $clog2(AddrMaxBits + 1),
  parameter int PCntW       = $clog2(SwapBits + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_start,
  input logic [1:0]       cmd_addr_mode,
  input logic             cmd_addr_swap_en,
  input logic             cmd_pay_swap_en,
  input logic [3:0]       cmd_pay_lanes,
  input logic             cmd_pay_dir,
  input logic             addr_phase,
  input logic             payload_phase,
  input logic             bit_valid,
  input logic             in_bit,
  input logic             out_bit,
  input logic [CntW-1:0]  addr_cnt,
  input logic [PCntW-1:0] pay_cnt
);
  logic             c_aoff, c_poff;
  logic [PCntW-1:0] c_pcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_aoff <= 1'b1;
      c_poff <= 1'b1;
      c_pcnt <= '0;
    end else if (cmd_start) begin
      c_aoff <= !cmd_addr_swap_en || (cmd_addr_mode == 2'b00);
      c_poff <= !(cmd_pay_swap_en && cmd_pay_lanes == 4'b0001 && !cmd_pay_dir);
      c_pcnt <= '0;
    end else if (bit_valid && payload_phase && !addr_phase && c_pcnt != PCntW'(SwapBits)) begin
      c_pcnt <= c_pcnt + PCntW'(1);
    end
  end

  a_r9_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid || (!addr_phase && !payload_phase)) |-> out_bit == in_bit);

  a_r4_addr_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (c_aoff && addr_phase) |-> out_bit == in_bit);

  a_r8_pay_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (c_poff && payload_phase && !addr_phase) |-> out_bit == in_bit);

  a_r7_tail_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (payload_phase && !addr_phase && c_pcnt == PCntW'(SwapBits)) |-> out_bit == in_bit);

  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> (addr_cnt == '0 && pay_cnt == '0));

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !cmd_start) |=> ($stable(addr_cnt) && $stable(pay_cnt)));

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cnt <= CntW'(AddrMaxBits));
endmodule

bind spi_pt_swap spi_pt_swap_chk #(.AddrMaxBits(AddrMaxBits), .SwapBits(SwapBits)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr_mode(cmd_addr_mode),
  .cmd_addr_swap_en(cmd_addr_swap_en), .cmd_pay_swap_en(cmd_pay_swap_en),
  .cmd_pay_lanes(cmd_pay_lanes), .cmd_pay_dir(cmd_pay_dir), .addr_phase(addr_phase),
  .payload_phase(payload_phase), .bit_valid(bit_valid), .in_bit(in_bit),
  .out_bit(out_bit), .addr_cnt(addr_cnt), .pay_cnt(pay_cnt)
);

// File: tb/test_spi_pt_swap.sv
`timescale 1ns/1ps
module test_spi_pt_swap;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_start = 0, cmd_addr_4b_cfg = 0, cmd_addr_swap_en = 0, cmd_pay_swap_en = 0, cmd_pay_dir = 0;
  logic [1:0] cmd_addr_mode = 0;
  logic [3:0] cmd_pay_lanes = 0;
  logic addr_phase = 0, payload_phase = 0, bit_valid = 0, in_bit = 0;
  logic [31:0] swap_addr = 32'hA5C3_0F96, pay_mask = 32'hF0F0_1234, pay_data = 32'h0FF0_AAAA;
  logic out_bit;

  int checks = 0, failures = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  bit m_aon, m_along, m_pon;
  int m_acnt, m_pcnt;

  always #2.5 clk = ~clk;

  spi_pt_swap i_spi_pt_swap (.*);

  function automatic bit model(bit v, bit a, bit p, bit b);
    bit e = b;
    int len;
    if (v && a) begin
      len = m_along ? 32 : 24;
      if (m_aon && m_acnt < len) e = swap_addr[len-1-m_acnt];
      if (m_acnt < 32) m_acnt++;
    end else if (v && p) begin
      if (m_pon && m_pcnt < 32) e = pay_mask[31-m_pcnt] ? pay_data[31-m_pcnt] : b;
      if (m_pcnt < 32) m_pcnt++;
    end
    return e;
  endfunction

  task automatic slot(bit v, bit a, bit p, bit b, string tag);
    bit_valid = v; addr_phase = a; payload_phase = p; in_bit = b;
    exp_q.push_back(model(v, a, p, b));
    tag_q.push_back(tag);
    @(posedge clk); #1;
  endtask

  task automatic start_cmd(logic [1:0] mode, bit cfg4, bit aswap, bit pswap, logic [3:0] lanes, bit dir, string tag);
    cmd_start = 1; cmd_addr_mode = mode; cmd_addr_4b_cfg = cfg4; cmd_addr_swap_en = aswap;
    cmd_pay_swap_en = pswap; cmd_pay_lanes = lanes; cmd_pay_dir = dir;
    slot(0, 0, 0, 1'($urandom), tag);
    m_aon = aswap && mode != 2'b00;
    m_along = (mode == 2'b11) || (mode == 2'b01 && cfg4);
    m_pon = pswap && lanes == 4'b0001 && !dir;
    m_acnt = 0; m_pcnt = 0;
    cmd_start = 0;
    cmd_addr_mode = ~mode; cmd_addr_4b_cfg = ~cfg4; cmd_addr_swap_en = ~aswap;
    cmd_pay_swap_en = ~pswap; cmd_pay_lanes = ~lanes; cmd_pay_dir = ~dir;
  endtask

  task automatic send_addr(logic [63:0] val, int n, string tag);
    for (int i = 0; i < n; i++) slot(1, 1, 0, val[n-1-i], tag);
  endtask

  task automatic send_pay(logic [63:0] val, int n, string tag);
    for (int i = 0; i < n; i++) slot(1, 0, 1, val[n-1-i], tag);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (out_bit !== e) begin
          failures++;
          $display("FAIL %s: out_bit=%0b expected=%0b", t, out_bit, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 5);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    m_aon = 0; m_along = 0; m_pon = 0; m_acnt = 0; m_pcnt = 0;
    #12 rst_n = 1;
    @(posedge clk); #1;
    // R11: no rewrite before first command
    swap_addr = 32'hFFFF_FFFF;
    send_addr(64'h0, 32, "R11");
    send_pay(64'h0, 32, "R11");
    swap_addr = 32'hA5C3_0F96;
    // R2 then R5: long address, extra bits pass
    start_cmd(2'b11, 0, 1, 0, 4'b0001, 0, "R10");
    send_addr(64'h1234_5678, 32, "R2");
    send_addr(64'hF, 4, "R5");
    // R1 then R5
    start_cmd(2'b10, 1, 1, 0, 4'b0001, 0, "R10");
    send_addr(64'h00_3C_5A_96, 24, "R1");
    send_addr(64'hA5, 8, "R5");
    // R3: config-resolved length
    start_cmd(2'b01, 1, 1, 0, 4'b0001, 0, "R3");
    send_addr(64'h0000_0000, 34, "R3");
    start_cmd(2'b01, 0, 1, 0, 4'b0001, 0, "R3");
    send_addr(64'hFFFF_FFFF, 32, "R3");
    // R4: disabled mode, or rewrite off
    start_cmd(2'b00, 1, 1, 0, 4'b0001, 0, "R4");
    send_addr(64'h5A5A_5A5A, 32, "R4");
    start_cmd(2'b11, 0, 0, 0, 4'b0001, 0, "R4");
    send_addr(64'hC3C3_3C3C, 32, "R4");
    // R6, R7: payload merge, tail passes
    start_cmd(2'b00, 0, 0, 1, 4'b0001, 0, "R10");
    send_pay(64'h00_5555_AAAA_3C, 40, "R6");
    send_pay(64'hFF00, 16, "R7");
    // R8: lane and direction gating
    start_cmd(2'b00, 0, 0, 1, 4'b0010, 0, "R8");
    send_pay(64'h0, 32, "R8");
    start_cmd(2'b00, 0, 0, 1, 4'b0001, 1, "R8");
    send_pay(64'h0, 32, "R8");
    start_cmd(2'b00, 0, 0, 0, 4'b0001, 0, "R8");
    send_pay(64'h0, 32, "R8");
    // R12: gaps with invalid slots
    start_cmd(2'b11, 0, 1, 1, 4'b0001, 0, "R10");
    for (int i = 0; i < 32; i++) begin
      slot(0, 1, 0, 1'($urandom), "R12");
      slot(1, 1, 0, 1'($urandom), "R12");
    end
    for (int i = 0; i < 34; i++) begin
      slot(0, 0, 1, 1'($urandom), "R12");
      slot(1, 0, 1, 1'($urandom), "R12");
    end
    // R9: valid slots outside phases, then combined command
    for (int i = 0; i < 8; i++) slot(1, 0, 0, 1'($urandom), "R9");
    start_cmd(2'b10, 0, 1, 1, 4'b0001, 0, "R10");
    send_addr(64'h0, 24, "R1");
    for (int i = 0; i < 3; i++) slot(1, 0, 0, 1'($urandom), "R9");
    send_pay(64'hFFFF_FFFF_FF, 40, "R6");
    // R10: restart mid address, new positions
    start_cmd(2'b11, 0, 1, 0, 4'b0001, 0, "R10");
    send_addr(64'h1F, 5, "R10");
    start_cmd(2'b11, 0, 1, 0, 4'b0001, 0, "R10");
    send_addr(64'h0, 32, "R10");
    // live preset value change
    swap_addr = 32'h1357_9BDF;
    start_cmd(2'b11, 0, 1, 0, 4'b0001, 0, "R2");
    send_addr(64'h0, 32, "R2");
    slot(0, 0, 0, 0, "R9");
    @(posedge clk); #1;
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule